// File: doc/BRIEF.md
# High-Speed Burst Lane Sequencer

This block drives the data lanes of a display serial link from the host side. It supports one or two lanes. Each lane rests in its low-power idle state. When a packet stream is offered, the block takes every active lane through the low-power entry steps and switches on the lane's high-speed driver. It sends a sync byte, then the payload bytes, then a trailer. Finally it returns the lane to idle. Traffic goes one way only, from host to display. The block never samples the lane lines.

Upstream logic offers the payload as beats with valid/ready and a last flag. A beat carries one byte per lane. In two-lane mode the low byte of a beat goes to lane 0 and the high byte goes to lane 1, so even-numbered bytes of the burst land on lane 0 and odd-numbered bytes on lane 1 in the same cycle. If a two-lane burst has an odd byte count, the final beat is marked half-full and only its low byte is sent.

Each lane has three outputs: its pair of single-ended line levels, an HS-enable flag, and the byte that goes to its serializer. The source must present one beat in every cycle of the payload phase.

Top module: `hs_burst_lane_seq`

## Requirements
- R1: After reset every lane shows lines {p,n} = 2'b11, HS enable is 0 on all lanes, and `busy` and `s_ready` are 0.
- R2: When a burst starts, each active lane shows lines 2'b01 for exactly LP_HOLD cycles, then 2'b00 for exactly LP_HOLD cycles. Its HS enable rises in the next cycle.
- R3: The first byte an active lane presents while HS enable is high is 8'hB8. This happens on every active lane in the same cycle, before any payload byte.
- R4: With `two_lane` = 0, every payload byte (`s_data[7:0]` of each beat) appears in order on lane 0, one byte per cycle. Lane 1 keeps lines 2'b11 and HS enable 0.
- R5: With `two_lane` = 1, burst byte 2k (`s_data[7:0]`) appears on lane 0 and byte 2k+1 (`s_data[15:8]`) appears on lane 1 in the same cycle. HS enable rises on both lanes in the same cycle.
- R6: After a lane's last byte it sends TRAIL_BYTES trailer bytes. Every bit of each trailer byte is the complement of bit 7 of the last byte sent on that lane, counting the sync byte. In the cycle after the trailer, HS enable is 0 and the lines are 2'b11.
- R7: In two-lane mode, a final beat with `s_last` = 1 and `s_half` = 1 carries only its low byte. Lane 1 then starts its trailer in the cycle in which lane 0 sends its last byte, and returns to 2'b11 one cycle before lane 0. With an even count both lanes return in the same cycle.
- R8: `s_ready` is 1 only during the payload phase. From idle, a beat offered at the start is first accepted after 2*LP_HOLD+2 clock edges. A beat offered while an earlier burst drains is held until then and is not consumed.
- R9: `busy` rises when a burst starts. Whenever `busy` is 0, every lane shows 2'b11 with HS enable 0.
- R10: `two_lane` is sampled when a burst starts. Changing it later in the burst has no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| two_lane | input | 1 | Use both lanes for the next burst |
| s_valid | input | 1 | Beat offered |
| s_data | input | 8*LANES | Beat bytes; lane i takes bits [8i+7:8i] |
| s_last | input | 1 | Beat is the last of the burst |
| s_half | input | 1 | With s_last in two-lane mode: only the low byte is valid |
| s_ready | output | 1 | Beat accepted at this edge |
| busy | output | 1 | A burst is in progress or a lane has not yet returned to idle |
| lane_lp | output | 2*LANES | Per-lane line levels {p,n} at [2i+1:2i] |
| lane_hs_en | output | LANES | Per-lane HS driver enable |
| lane_hs_byte | output | 8*LANES | Per-lane byte to the serializer at [8i+7:8i] |

## Verification
Two functions can fall in the same cycle on an odd-length two-lane burst. Lane 1 begins its trailer in the very cycle lane 0 sends its final payload byte, and it leaves HS one cycle sooner. The bench provokes this with half-full final beats, including a single-byte burst where lane 1 carries only the sync byte. A per-lane expected-byte queue judges every HS byte, and the recorded exit cycles of the two lanes must differ by exactly one. A second overlap is a new beat offered while the previous burst drains: the queues show that the beat waits out the drain and the full entry sequence before it is sent.

// File: rtl/hsl_pkg.sv
package hsl_pkg;

    typedef enum logic [1:0] {
        LINES_00 = 2'b00,
        LINES_01 = 2'b01,
        LINES_10 = 2'b10,
        LINES_11 = 2'b11
    } line_lvl_e;

    typedef enum logic [2:0] {
        C_IDLE,
        C_REQ,
        C_BRIDGE,
        C_SYNC,
        C_PAY,
        C_DRAIN
    } ctrl_st_e;

    typedef enum logic [1:0] {
        L_REST,
        L_SEND,
        L_TAIL
    } lane_st_e;

    typedef struct packed {
        line_lvl_e   lvl;
        logic        start;
        logic        dvld;
        logic [7:0]  data;
        logic        fin;
    } lane_cmd_t;

    localparam logic [7:0] HS_LEAD_BYTE = 8'hB8;

    function automatic logic [7:0] tail_fill(input logic last_bit);
        return {8{~last_bit}};
    endfunction

endpackage

// File: rtl/hsl_entry_ctrl.sv
module hsl_entry_ctrl
    import hsl_pkg::*;
#(
    parameter int LANES   = 2,
    parameter int LP_HOLD = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      two_lane,
    input  logic                      s_valid,
    input  logic [8*LANES-1:0]        s_data,
    input  logic                      s_last,
    input  logic                      s_half,
    input  logic                      lanes_rest,
    output logic                      s_ready,
    output logic                      busy,
    output lane_cmd_t [LANES-1:0]     cmd
);

    localparam int CW = (LP_HOLD > 1) ? $clog2(LP_HOLD) : 1;
    localparam logic [CW-1:0] HOLD_END = CW'(LP_HOLD - 1);

    ctrl_st_e        st;
    logic [CW-1:0]   hold_cnt;
    logic            two_q;
    logic [LANES-1:0] act;
    logic            hold_done;

    assign hold_done = (hold_cnt == HOLD_END);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= C_IDLE;
            hold_cnt <= '0;
            two_q    <= 1'b0;
        end else begin
            case (st)
                C_IDLE: begin
                    hold_cnt <= '0;
                    if (s_valid) begin
                        st    <= C_REQ;
                        two_q <= two_lane;
                    end
                end
                C_REQ: begin
                    if (hold_done) begin
                        st       <= C_BRIDGE;
                        hold_cnt <= '0;
                    end else begin
                        hold_cnt <= hold_cnt + 1'b1;
                    end
                end
                C_BRIDGE: begin
                    if (hold_done) begin
                        st       <= C_SYNC;
                        hold_cnt <= '0;
                    end else begin
                        hold_cnt <= hold_cnt + 1'b1;
                    end
                end
                C_SYNC:  st <= C_PAY;
                C_PAY:   if (s_valid && s_last) st <= C_DRAIN;
                C_DRAIN: if (lanes_rest) st <= C_IDLE;
                default: st <= C_IDLE;
            endcase
        end
    end

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_act
            if (i == 0) begin : g_first
                assign act[i] = 1'b1;
            end else begin : g_other
                assign act[i] = two_q;
            end
        end
    endgenerate

    assign s_ready = (st == C_PAY);
    assign busy    = (st != C_IDLE);

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            cmd[i].lvl   = LINES_11;
            cmd[i].start = 1'b0;
            cmd[i].dvld  = 1'b0;
            cmd[i].fin   = 1'b0;
            cmd[i].data  = s_data[8*i +: 8];
            if (act[i]) begin
                case (st)
                    C_REQ:    cmd[i].lvl   = LINES_01;
                    C_BRIDGE: cmd[i].lvl   = LINES_00;
                    C_SYNC: begin
                        cmd[i].lvl   = LINES_00;
                        cmd[i].start = 1'b1;
                    end
                    C_PAY: begin
                        cmd[i].lvl  = LINES_00;
                        cmd[i].fin  = s_valid && s_last;
                        if (i == 0) cmd[i].dvld = s_valid;
                        else        cmd[i].dvld = s_valid && !(s_last && s_half);
                    end
                    default: cmd[i].lvl = LINES_11;
                endcase
            end
        end
    end

endmodule

// File: rtl/hsl_lane.sv
module hsl_lane
    import hsl_pkg::*;
#(
    parameter int TRAIL_BYTES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  lane_cmd_t  cmd,
    output logic [1:0] lp,
    output logic       hs_en,
    output logic [7:0] hs_byte,
    output logic       at_rest
);

    localparam int TW = $clog2(TRAIL_BYTES + 1);
    localparam logic [TW-1:0] TAIL_END = TW'(TRAIL_BYTES);

    lane_st_e      st;
    line_lvl_e     lvl_q;
    logic          hs_q;
    logic [7:0]    byte_q;
    logic          last_bit;
    logic [TW-1:0] tail_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= L_REST;
            lvl_q    <= LINES_11;
            hs_q     <= 1'b0;
            byte_q   <= '0;
            last_bit <= 1'b0;
            tail_cnt <= '0;
        end else begin
            case (st)
                L_REST: begin
                    lvl_q <= cmd.lvl;
                    if (cmd.start) begin
                        st       <= L_SEND;
                        lvl_q    <= LINES_00;
                        hs_q     <= 1'b1;
                        byte_q   <= HS_LEAD_BYTE;
                        last_bit <= HS_LEAD_BYTE[7];
                    end
                end
                L_SEND: begin
                    if (cmd.dvld) begin
                        byte_q   <= cmd.data;
                        last_bit <= cmd.data[7];
                        if (cmd.fin) begin
                            st       <= L_TAIL;
                            tail_cnt <= '0;
                        end
                    end else if (cmd.fin) begin
                        st       <= L_TAIL;
                        byte_q   <= tail_fill(last_bit);
                        tail_cnt <= TW'(1);
                    end
                end
                L_TAIL: begin
                    if (tail_cnt == TAIL_END) begin
                        st     <= L_REST;
                        hs_q   <= 1'b0;
                        lvl_q  <= LINES_11;
                        byte_q <= '0;
                    end else begin
                        byte_q   <= tail_fill(last_bit);
                        tail_cnt <= tail_cnt + 1'b1;
                    end
                end
                default: st <= L_REST;
            endcase
        end
    end

    assign lp      = lvl_q;
    assign hs_en   = hs_q;
    assign hs_byte = byte_q;
    assign at_rest = (st == L_REST);

endmodule

// File: rtl/hs_burst_lane_seq.sv
module hs_burst_lane_seq
    import hsl_pkg::*;
#(
    parameter int LANES       = 2,
    parameter int LP_HOLD     = 4,
    parameter int TRAIL_BYTES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 two_lane,
    input  logic                 s_valid,
    input  logic [8*LANES-1:0]   s_data,
    input  logic                 s_last,
    input  logic                 s_half,
    output logic                 s_ready,
    output logic                 busy,
    output logic [2*LANES-1:0]   lane_lp,
    output logic [LANES-1:0]     lane_hs_en,
    output logic [8*LANES-1:0]   lane_hs_byte
);

    lane_cmd_t [LANES-1:0] cmd;
    logic [LANES-1:0]      rest_v;

    hsl_entry_ctrl #(
        .LANES   (LANES),
        .LP_HOLD (LP_HOLD)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .two_lane   (two_lane),
        .s_valid    (s_valid),
        .s_data     (s_data),
        .s_last     (s_last),
        .s_half     (s_half),
        .lanes_rest (&rest_v),
        .s_ready    (s_ready),
        .busy       (busy),
        .cmd        (cmd)
    );

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            hsl_lane #(
                .TRAIL_BYTES (TRAIL_BYTES)
            ) u_lane (
                .clk     (clk),
                .rst     (rst),
                .cmd     (cmd[i]),
                .lp      (lane_lp[2*i +: 2]),
                .hs_en   (lane_hs_en[i]),
                .hs_byte (lane_hs_byte[8*i +: 8]),
                .at_rest (rest_v[i])
            );
        end
    endgenerate

endmodule

// File: rtl/hsl_checker.sv
module hsl_checker #(
    parameter int LANES = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 busy,
    input logic                 s_ready,
    input logic [2*LANES-1:0]   lane_lp,
    input logic [LANES-1:0]     lane_hs_en,
    input logic [8*LANES-1:0]   lane_hs_byte
);

    p_quiet_when_free_r9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (lane_lp == {2*LANES{1'b1}}) && (lane_hs_en == '0));

    p_ready_in_hs_r8: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> lane_hs_en[0]);

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_pl
            p_enter_from_00_r2: assert property (@(posedge clk) disable iff (rst)
                $rose(lane_hs_en[i]) |-> ($past(lane_lp[2*i +: 2]) == 2'b00));

            p_lead_byte_r3: assert property (@(posedge clk) disable iff (rst)
                $rose(lane_hs_en[i]) |-> (lane_hs_byte[8*i +: 8] == 8'hB8));

            p_exit_to_11_r6: assert property (@(posedge clk) disable iff (rst)
                $fell(lane_hs_en[i]) |-> (lane_lp[2*i +: 2] == 2'b11));
        end
        if (LANES > 1) begin : g_pair
            p_lane1_inside_r7: assert property (@(posedge clk) disable iff (rst)
                lane_hs_en[1] |-> lane_hs_en[0]);

            p_joint_start_r5: assert property (@(posedge clk) disable iff (rst)
                $rose(lane_hs_en[1]) |-> $rose(lane_hs_en[0]));
        end
    endgenerate

endmodule

bind hs_burst_lane_seq hsl_checker #(.LANES(LANES)) u_hsl_checker (
    .clk          (clk),
    .rst          (rst),
    .busy         (busy),
    .s_ready      (s_ready),
    .lane_lp      (lane_lp),
    .lane_hs_en   (lane_hs_en),
    .lane_hs_byte (lane_hs_byte)
);

// File: tb/tb_hs_burst_lane_seq.sv
module tb_hs_burst_lane_seq;

    localparam int LANES = 2;
    localparam int H     = 4;
    localparam int T     = 2;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                two_lane = 1'b0;
    logic                s_valid = 1'b0;
    logic [8*LANES-1:0]  s_data = '0;
    logic                s_last = 1'b0;
    logic                s_half = 1'b0;
    logic                s_ready;
    logic                busy;
    logic [2*LANES-1:0]  lane_lp;
    logic [LANES-1:0]    lane_hs_en;
    logic [8*LANES-1:0]  lane_hs_byte;

    hs_burst_lane_seq #(.LANES(LANES), .LP_HOLD(H), .TRAIL_BYTES(T)) dut (
        .clk(clk), .rst(rst), .two_lane(two_lane), .s_valid(s_valid),
        .s_data(s_data), .s_last(s_last), .s_half(s_half), .s_ready(s_ready),
        .busy(busy), .lane_lp(lane_lp), .lane_hs_en(lane_hs_en),
        .lane_hs_byte(lane_hs_byte)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] q0[$];
    logic [7:0] q1[$];
    int  cyc = 0;
    int  fall_cyc [2];
    int  run01 [2];
    int  run00 [2];
    bit  prev_hs [2];
    bit  watch_l1 = 1'b0;
    int  l1_stray = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: scoreboard pop and entry-sequence tracking
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            for (int i = 0; i < 2; i++) begin
                logic [1:0] lv;
                logic [7:0] by;
                logic       hs;
                lv = lane_lp[2*i +: 2];
                by = lane_hs_byte[8*i +: 8];
                hs = lane_hs_en[i];
                if (hs) begin
                    if (!prev_hs[i]) begin
                        chk(run01[i] == H, "R2 lines 01 run", run01[i], H);
                        chk(run00[i] == H, "R2 lines 00 run", run00[i], H);
                    end
                    if (i == 0) begin
                        if (q0.size() == 0) chk(0, "R6 lane0 extra HS byte", by, 0);
                        else begin
                            logic [7:0] e;
                            e = q0.pop_front();
                            chk(by == e, "R3/R4/R5/R6 lane0 byte", by, e);
                        end
                    end else begin
                        if (q1.size() == 0) chk(0, "R4/R6 lane1 extra HS byte", by, 0);
                        else begin
                            logic [7:0] e;
                            e = q1.pop_front();
                            chk(by == e, "R3/R5/R6 lane1 byte", by, e);
                        end
                    end
                    run01[i] = 0;
                    run00[i] = 0;
                end else begin
                    if (prev_hs[i]) begin
                        fall_cyc[i] = cyc;
                        chk(lv == 2'b11, "R6 lines after trailer", lv, 2'b11);
                    end
                    if (lv == 2'b01) run01[i]++;
                    else if (lv == 2'b00) run00[i]++;
                    else begin
                        run01[i] = 0;
                        run00[i] = 0;
                    end
                end
                prev_hs[i] = hs;
            end
            if (watch_l1 && (lane_lp[3:2] != 2'b11 || lane_hs_en[1])) l1_stray++;
        end
    end

    function automatic logic [7:0] fill(input logic [7:0] b);
        return {8{~b[7]}};
    endfunction

    task automatic wait_free();
        @(negedge clk);
        while (busy) @(negedge clk);
        chk(q0.size() == 0 && q1.size() == 0, "R6 all bytes sent", q0.size() + q1.size(), 0);
        chk(lane_lp == 4'b1111 && lane_hs_en == 2'b00, "R9 idle when not busy",
            {lane_lp, lane_hs_en}, 6'b111100);
    endtask

    task automatic send_burst(input bit two, input int n, input int seed,
                              input bit from_idle, input bit flip);
        logic [7:0] d[$];
        logic [7:0] l0, l1;
        int beats, w;
        for (int k = 0; k < n; k++) d.push_back(8'((seed + k * 53 + k * k * 7) & 255));
        q0.push_back(8'hB8);
        l0 = 8'hB8;
        if (two) begin
            q1.push_back(8'hB8);
            l1 = 8'hB8;
            for (int k = 0; k < n; k++) begin
                if (k % 2 == 0) begin q0.push_back(d[k]); l0 = d[k]; end
                else            begin q1.push_back(d[k]); l1 = d[k]; end
            end
            for (int k = 0; k < T; k++) q1.push_back(fill(l1));
            beats = (n + 1) / 2;
        end else begin
            for (int k = 0; k < n; k++) begin q0.push_back(d[k]); l0 = d[k]; end
            beats = n;
        end
        for (int k = 0; k < T; k++) q0.push_back(fill(l0));
        for (int b = 0; b < beats; b++) begin
            @(negedge clk);
            if (b == 0) two_lane = two;
            s_valid = 1'b1;
            if (two) begin
                s_data = {(2*b+1 < n) ? d[2*b+1] : 8'h00, d[2*b]};
                s_half = (2*b+1 >= n);
            end else begin
                s_data = {8'hA5, d[b]};
                s_half = 1'b0;
            end
            s_last = (b == beats - 1);
            w = 0;
            while (!s_ready) begin
                w++;
                @(negedge clk);
            end
            if (b == 0 && from_idle) chk(w == 2*H + 2, "R8 first accept delay", w, 2*H + 2);
            @(posedge clk);
            if (b == 0 && flip) two_lane = ~two;
        end
        @(negedge clk);
        s_valid = 1'b0;
        s_last  = 1'b0;
        s_half  = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 2; i++) begin
            fall_cyc[i] = 0; run01[i] = 0; run00[i] = 0; prev_hs[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(lane_lp == 4'b1111, "R1 reset lines", lane_lp, 4'b1111);
        chk(lane_hs_en == 2'b00, "R1 reset hs enable", lane_hs_en, 0);
        chk(busy == 1'b0 && s_ready == 1'b0, "R1 reset busy/ready", {busy, s_ready}, 0);

        // single lane, five bytes; lane 1 must stay idle
        watch_l1 = 1'b1;
        l1_stray = 0;
        send_burst(1'b0, 5, 8'h17, 1'b1, 1'b0);
        @(negedge clk);
        chk(busy == 1'b1, "R9 busy during trailer", busy, 1);
        wait_free();
        chk(l1_stray == 0, "R4 lane1 untouched in one-lane mode", l1_stray, 0);
        watch_l1 = 1'b0;

        // two lanes, even count: equal exit
        send_burst(1'b1, 6, 8'h81, 1'b1, 1'b0);
        wait_free();
        chk(fall_cyc[0] == fall_cyc[1], "R7 even count joint exit", fall_cyc[0] - fall_cyc[1], 0);

        // two lanes, odd count, lane select flipped mid-burst
        send_burst(1'b1, 5, 8'h3C, 1'b1, 1'b1);
        wait_free();
        chk(fall_cyc[0] - fall_cyc[1] == 1, "R7 odd count early lane1 exit", fall_cyc[0] - fall_cyc[1], 1);

        // two lanes, a single byte: lane1 carries only sync then trailer 00
        send_burst(1'b1, 1, 8'hF0, 1'b1, 1'b0);
        wait_free();
        chk(fall_cyc[0] - fall_cyc[1] == 1, "R7 one-byte early lane1 exit", fall_cyc[0] - fall_cyc[1], 1);

        // one lane, single byte with bit7 = 0 -> trailer FF; flip must not widen the burst (R10)
        watch_l1 = 1'b1;
        l1_stray = 0;
        send_burst(1'b0, 1, 8'h22, 1'b1, 1'b1);
        wait_free();
        chk(l1_stray == 0, "R10 late two_lane change ignored", l1_stray, 0);
        watch_l1 = 1'b0;

        // back to back: second burst offered during drain (R8)
        send_burst(1'b1, 7, 8'h5D, 1'b1, 1'b0);
        send_burst(1'b0, 4, 8'hC9, 1'b0, 1'b0);
        send_burst(1'b1, 8, 8'h6B, 1'b0, 1'b0);
        wait_free();

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule